// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block decides when a DMA channel raises its interrupt line. It merges three event sources into one level interrupt. The first source is a batch counter for completed descriptors that carry an interrupt-on-complete flag. The second is an idle timer that starts at the end of a packet. The third is an error flag. Each source sets a sticky status bit. Software clears a status bit by writing 1 to it. The interrupt output is high while any status bit and its enable are both set.

Software loads the configuration in a single write strobe. That write carries an 8-bit batch size, an 8-bit idle delay counted in units of 125 clock cycles, and three enables. The batch counter counts down from the batch size. A delay of zero turns the idle timer off. When the idle timer expires, the partial batch is discarded, so those completions are not counted a second time. A synchronous soft-reset input returns every field, counter and status bit to its reset value.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After the batch size N (thresh_o) IOC-flagged completions, status bit 0 (sts_o[0]) is 1 on the clock edge that samples the Nth completion. The counter then reloads, so the next report needs N more completions.
- R2: After reset, thresh_o is 1. A configuration write whose batch field is 0 leaves thresh_o unchanged. Any nonzero value is stored.
- R3: A completion pulse with desc_ioc_i = 0 does not count toward the batch.
- R4: With delay field D > 0, status bit 1 (sts_o[1]) is set on the clock edge that comes 125·D cycles after the edge that samples pkt_eop_i.
- R5: A pkt_sop_i pulse stops a running idle timer without setting bit 1. A later pkt_eop_i starts a full new interval.
- R6: A delay field of 0 never sets status bit 1.
- R7: When the idle timer expires, the batch counter reloads from the batch size. Completions made before the timeout no longer count.
- R8: An err_i pulse sets status bit 2 (sts_o[2]) on the edge that samples it.
- R9: Status bits are sticky. Writing clr_i bit k = 1 clears bit k. A set and a clear of the same bit in one cycle leaves the bit set.
- R10: irq_o is 1 exactly when some sts_o[k] and en_o[k] are both 1. Enable bit order: 0 = IOC, 1 = delay, 2 = error.
- R11: A soft_rst_i pulse sets, on the next edge: thresh_o = 1, delay_o = 0, en_o = 0, sts_o = 0 and irq_o = 0.
- R12: A configuration write with a nonzero batch size reloads the batch counter. Completions already counted are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_thresh_i | input | 8 | Batch size (write of 0 ignored) |
| cfg_delay_i | input | 8 | Idle delay in 125-cycle units |
| cfg_en_i | input | 3 | Enables: IOC, delay, error |
| clr_i | input | 3 | Write-1-to-clear for status bits |
| desc_done_i | input | 1 | Descriptor completion pulse |
| desc_ioc_i | input | 1 | IOC flag of the completing descriptor |
| pkt_sop_i | input | 1 | Start-of-packet strobe |
| pkt_eop_i | input | 1 | End-of-packet strobe |
| err_i | input | 1 | Error pulse |
| thresh_o | output | 8 | Stored batch size |
| delay_o | output | 8 | Stored idle delay |
| en_o | output | 3 | Stored enables |
| sts_o | output | 3 | Sticky status: IOC, delay, error |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted batch counter shows at sts_o[0]. The report comes one or more completions early or late, and it shows within a single batch of pulses. The reload check after a report or a timeout catches a counter that did not reload. An idle timer with a wrong prescale or a missed restart moves the rise of sts_o[1] away from the exact 125·D-cycle edge, so the bench samples one cycle before that edge and on it. Sticky or masking faults show at irq_o and sts_o on the cycle after a clear, an error or an enable write.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned NUM_SRC = 3;
  typedef enum logic [1:0] {
    SRC_IOC = 2'd0,
    SRC_DLY = 2'd1,
    SRC_ERR = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_batch_cnt.sv
module irq_batch_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             reload_i,
  input  logic             event_i,
  output logic [CNT_W-1:0] thresh_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] thresh_q, cnt_q, base;
  logic             accept;

  assign accept   = we_i && (thresh_i != '0);
  // a timeout reload is applied before a same-cycle event is counted
  assign base     = reload_i ? thresh_q : cnt_q;
  assign fire_o   = event_i && !accept && !soft_rst_i && (base == ONE);
  assign thresh_o = thresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_q <= ONE;
      cnt_q    <= ONE;
    end else if (soft_rst_i) begin
      thresh_q <= ONE;
      cnt_q    <= ONE;
    end else if (accept) begin
      thresh_q <= thresh_i;
      cnt_q    <= thresh_i;
    end else if (event_i) begin
      cnt_q <= (base == ONE) ? thresh_q : base - ONE;
    end else begin
      cnt_q <= base;
    end
  end
endmodule

// File: rtl/irq_idle_timer.sv
module irq_idle_timer #(
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned TICK_DIV = 125
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             we_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             sop_i,
  input  logic             eop_i,
  output logic [DLY_W-1:0] delay_o,
  output logic             fire_o
);
  localparam int unsigned PRE_W = $clog2(TICK_DIV);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);

  logic [DLY_W-1:0] delay_q, unit_q;
  logic [PRE_W-1:0] pre_q;
  logic             run_q, armed, wrap;

  assign armed   = run_q && (delay_q != '0);
  assign wrap    = (pre_q == PRE_MAX);
  assign fire_o  = armed && wrap && (unit_q >= delay_q - DLY_W'(1))
                   && !eop_i && !sop_i && !soft_rst_i;
  assign delay_o = delay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q <= '0;
      run_q   <= 1'b0;
      pre_q   <= '0;
      unit_q  <= '0;
    end else if (soft_rst_i) begin
      delay_q <= '0;
      run_q   <= 1'b0;
      pre_q   <= '0;
      unit_q  <= '0;
    end else begin
      if (we_i) delay_q <= delay_i;
      if (eop_i) begin
        run_q  <= 1'b1;
        pre_q  <= '0;
        unit_q <= '0;
      end else if (sop_i || fire_o) begin
        run_q  <= 1'b0;
        pre_q  <= '0;
        unit_q <= '0;
      end else if (armed) begin
        pre_q <= wrap ? '0 : pre_q + PRE_W'(1);
        if (wrap) unit_q <= unit_q + DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= '0;
    else if (soft_rst_i) en_q <= '0;
    else if (en_we_i)    en_q <= en_i;
  end

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sts_q[k] <= 1'b0;
      else if (soft_rst_i) sts_q[k] <= 1'b0;
      else if (set_i[k])   sts_q[k] <= 1'b1;
      else if (clr_i[k])   sts_q[k] <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_q);
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
  import dma_irq_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned TICK_DIV = 125
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               cfg_we_i,
  input  logic [CNT_W-1:0]   cfg_thresh_i,
  input  logic [DLY_W-1:0]   cfg_delay_i,
  input  logic [NUM_SRC-1:0] cfg_en_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               desc_done_i,
  input  logic               desc_ioc_i,
  input  logic               pkt_sop_i,
  input  logic               pkt_eop_i,
  input  logic               err_i,
  output logic [CNT_W-1:0]   thresh_o,
  output logic [DLY_W-1:0]   delay_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] sts_o,
  output logic               irq_o
);
  logic               ioc_fire, dly_fire;
  logic [NUM_SRC-1:0] set;

  irq_batch_cnt #(.CNT_W(CNT_W)) u_batch (
    .clk_i, .rst_ni, .soft_rst_i,
    .we_i     (cfg_we_i),
    .thresh_i (cfg_thresh_i),
    .reload_i (dly_fire),
    .event_i  (desc_done_i && desc_ioc_i),
    .thresh_o (thresh_o),
    .fire_o   (ioc_fire)
  );

  irq_idle_timer #(.DLY_W(DLY_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk_i, .rst_ni, .soft_rst_i,
    .we_i    (cfg_we_i),
    .delay_i (cfg_delay_i),
    .sop_i   (pkt_sop_i),
    .eop_i   (pkt_eop_i),
    .delay_o (delay_o),
    .fire_o  (dly_fire)
  );

  always_comb begin
    set          = '0;
    set[SRC_IOC] = ioc_fire;
    set[SRC_DLY] = dly_fire;
    set[SRC_ERR] = err_i;
  end

  irq_status #(.N(NUM_SRC)) u_status (
    .clk_i, .rst_ni, .soft_rst_i,
    .en_we_i (cfg_we_i),
    .en_i    (cfg_en_i),
    .set_i   (set),
    .clr_i   (clr_i),
    .en_o    (en_o),
    .sts_o   (sts_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/dma_irq_coalesce_chk.sv
module dma_irq_coalesce_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DLY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic             cfg_we_i,
  input logic [CNT_W-1:0] cfg_thresh_i,
  input logic [2:0]       clr_i,
  input logic             desc_done_i,
  input logic             desc_ioc_i,
  input logic             err_i,
  input logic [CNT_W-1:0] thresh_o,
  input logic [DLY_W-1:0] delay_o,
  input logic [2:0]       en_o,
  input logic [2:0]       sts_o,
  input logic             irq_o
);
  assert_zero_write_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_thresh_i == '0 && !soft_rst_i) |=> $stable(thresh_o));

  assert_single_batch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_o == CNT_W'(1) && desc_done_i && desc_ioc_i && !cfg_we_i && !soft_rst_i)
      |=> sts_o[0]);

  assert_no_delay_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delay_o == '0 && !soft_rst_i) |=> !$rose(sts_o[1]));

  assert_err_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !soft_rst_i) |=> sts_o[2]);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[2] && !clr_i[2] && !soft_rst_i) |=> sts_o[2]);

  assert_soft_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (sts_o == '0 && en_o == '0 && !irq_o
                    && thresh_o == CNT_W'(1) && delay_o == '0));
endmodule

bind dma_irq_coalesce dma_irq_coalesce_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
  .clk_i, .rst_ni, .soft_rst_i, .cfg_we_i, .cfg_thresh_i, .clr_i,
  .desc_done_i, .desc_ioc_i, .err_i,
  .thresh_o, .delay_o, .en_o, .sts_o, .irq_o
);

// File: tb/dma_irq_coalesce_test.sv
module dma_irq_coalesce_test;
  logic       clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_thresh_i = '0, cfg_delay_i = '0;
  logic [2:0] cfg_en_i = '0, clr_i = '0;
  logic       desc_done_i = 1'b0, desc_ioc_i = 1'b0;
  logic       pkt_sop_i = 1'b0, pkt_eop_i = 1'b0, err_i = 1'b0;
  logic [7:0] thresh_o, delay_o;
  logic [2:0] en_o, sts_o;
  logic       irq_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_irq_coalesce uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cfg(logic [7:0] th, logic [7:0] dl, logic [2:0] en);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_thresh_i = th; cfg_delay_i = dl; cfg_en_i = en;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear(logic [2:0] m);
    @(negedge clk_i); clr_i = m;
    @(negedge clk_i); clr_i = '0;
  endtask

  task automatic compl(logic ioc);
    @(negedge clk_i); desc_done_i = 1'b1; desc_ioc_i = ioc;
    @(negedge clk_i); desc_done_i = 1'b0; desc_ioc_i = 1'b0;
  endtask

  task automatic eop();
    @(negedge clk_i); pkt_eop_i = 1'b1;
    @(negedge clk_i); pkt_eop_i = 1'b0;
  endtask

  task automatic sop();
    @(negedge clk_i); pkt_sop_i = 1'b1;
    @(negedge clk_i); pkt_sop_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset thresh", 32'(thresh_o), 1);
    chk("R11 reset delay", 32'(delay_o), 0);
    chk("R11 reset sts", 32'(sts_o), 0);
    chk("R10 reset irq", 32'(irq_o), 0);
  endtask

  task automatic t_zero_write();
    cfg(8'd4, 8'd0, 3'b000);
    chk("R2 store 4", 32'(thresh_o), 4);
    cfg(8'd0, 8'd0, 3'b000);
    chk("R2 zero kept", 32'(thresh_o), 4);
  endtask

  task automatic t_batch();
    cfg(8'd3, 8'd0, 3'b001);
    compl(1'b1); compl(1'b1);
    chk("R1 two of three", 32'(sts_o[0]), 0);
    compl(1'b0);
    chk("R3 no-flag ignored", 32'(sts_o[0]), 0);
    compl(1'b1);
    chk("R1 third sets", 32'(sts_o[0]), 1);
    chk("R10 irq on", 32'(irq_o), 1);
    clear(3'b001);
    chk("R9 w1c", 32'(sts_o[0]), 0);
    chk("R10 irq off", 32'(irq_o), 0);
    compl(1'b1); compl(1'b1);
    chk("R1 reload partial", 32'(sts_o[0]), 0);
    compl(1'b1);
    chk("R1 reload full", 32'(sts_o[0]), 1);
    clear(3'b001);
  endtask

  task automatic t_write_reload();
    cfg(8'd3, 8'd0, 3'b001);
    compl(1'b1); compl(1'b1);
    cfg(8'd2, 8'd0, 3'b001);
    compl(1'b1);
    chk("R12 reload after write", 32'(sts_o[0]), 0);
    compl(1'b1);
    chk("R12 new batch", 32'(sts_o[0]), 1);
    clear(3'b001);
  endtask

  task automatic t_delay();
    cfg(8'd2, 8'd2, 3'b010);
    eop();
    wait_n(249);
    chk("R4 before 250", 32'(sts_o[1]), 0);
    wait_n(1);
    chk("R4 at 250", 32'(sts_o[1]), 1);
    chk("R10 delay irq", 32'(irq_o), 1);
    clear(3'b010);
  endtask

  task automatic t_sop_cancel();
    eop();
    wait_n(100);
    sop();
    wait_n(300);
    chk("R5 cancelled", 32'(sts_o[1]), 0);
    eop();
    wait_n(249);
    chk("R5 restart early", 32'(sts_o[1]), 0);
    wait_n(1);
    chk("R5 restart full", 32'(sts_o[1]), 1);
    clear(3'b010);
  endtask

  task automatic t_delay_zero();
    cfg(8'd2, 8'd0, 3'b010);
    eop();
    wait_n(400);
    chk("R6 disabled", 32'(sts_o[1]), 0);
  endtask

  task automatic t_timeout_reload();
    cfg(8'd3, 8'd1, 3'b011);
    compl(1'b1); compl(1'b1);
    eop();
    wait_n(125);
    chk("R7 timeout", 32'(sts_o), 3'b010);
    clear(3'b111);
    compl(1'b1); compl(1'b1);
    chk("R7 partial dropped", 32'(sts_o[0]), 0);
    compl(1'b1);
    chk("R7 fresh batch", 32'(sts_o[0]), 1);
    clear(3'b111);
  endtask

  task automatic t_error();
    cfg(8'd3, 8'd0, 3'b000);
    @(negedge clk_i); err_i = 1'b1;
    @(negedge clk_i); err_i = 1'b0;
    chk("R8 err set", 32'(sts_o[2]), 1);
    chk("R10 masked", 32'(irq_o), 0);
    cfg(8'd3, 8'd0, 3'b100);
    chk("R10 unmasked", 32'(irq_o), 1);
    @(negedge clk_i); err_i = 1'b1; clr_i = 3'b100;
    @(negedge clk_i); err_i = 1'b0; clr_i = 3'b000;
    chk("R9 set wins", 32'(sts_o[2]), 1);
    clear(3'b100);
    chk("R9 cleared", 32'(sts_o[2]), 0);
  endtask

  task automatic t_soft();
    cfg(8'd7, 8'd5, 3'b111);
    @(negedge clk_i); err_i = 1'b1;
    @(negedge clk_i); err_i = 1'b0;
    chk("R11 pre irq", 32'(irq_o), 1);
    @(negedge clk_i); soft_rst_i = 1'b1;
    @(negedge clk_i); soft_rst_i = 1'b0;
    chk("R11 thresh", 32'(thresh_o), 1);
    chk("R11 delay", 32'(delay_o), 0);
    chk("R11 en", 32'(en_o), 0);
    chk("R11 sts", 32'(sts_o), 0);
    chk("R11 irq", 32'(irq_o), 0);
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    t_reset();
    t_zero_write();
    t_batch();
    t_write_reload();
    t_delay();
    t_sop_cancel();
    t_delay_zero();
    t_timeout_reload();
    t_error();
    t_soft();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule